// File: doc/BRIEF.md
# Byte-Wide Bus Interface with Instruction Prefetch

This block connects a 16-bit execution side to a memory bus that is only 8 bits wide. It serves two kinds of traffic. The first is data reads and writes of byte or word size, which the execution side requests. The second is a background stream of instruction bytes, which runs ahead into a small queue. Every external transfer moves one byte, and every bus cycle lasts a fixed number of clocks. A word operand therefore costs two back-to-back byte cycles, which the block sequences by itself. The rate at which instruction bytes can arrive is capped by the same bus.

The execution side holds a request until a one-cycle completion pulse arrives. It pops instruction bytes from the head of the queue. When the queue is empty, a pop has no effect, and the consumer waits for the valid flag. A control-flow change is signalled with a flush pulse and a new fetch address. The flush empties the queue and restarts prefetch from that address. A byte cycle already on the bus always runs to its end. If that cycle is a fetch, its byte is thrown away.

Top module: `byte_bus_unit`

## Requirements
- R1: Each external bus cycle moves one byte. It drives exactly one of the read or write strobes for exactly 4 consecutive clocks, with the address held for the whole cycle.
- R2: A byte read returns the byte found at the requested address on the low half of the read data, with the high half zero. The completion pulse appears 4 clocks after the clock edge that accepts the request, provided the bus is idle.
- R3: A word read uses two back-to-back byte cycles: first at the address, then at the address plus one. The first byte forms bits 7:0 of the result and the second forms bits 15:8. Completion is signalled only after the second cycle, 8 clocks after acceptance.
- R4: A word write drives write data bits 7:0 at the address, then bits 15:8 at the address plus one. The data stays steady during each cycle.
- R5: Prefetch reads consecutive addresses into a 4-byte queue, and the queue delivers them oldest first. A fetch cycle starts only when a slot will be free, so a full queue with no data request leaves the bus idle.
- R6: The valid flag is high exactly when the queue holds a byte, and the head byte is shown alongside it. A pop while the queue is empty is ignored.
- R7: A pending data request takes the bus at the next bus-cycle boundary, ahead of prefetch. A fetch already running is not cut short, so a byte read issued during active prefetch completes within 4 to 7 clocks after the first edge that sees it. The fetched stream stays intact.
- R8: A flush empties the queue by the next cycle. It discards the byte of any fetch in flight, and the next bytes delivered start at the flush address.
- R9: During reset, both strobes, the completion pulse and the valid flag are low. The first bus cycle after reset is a fetch from the reset fetch address, which is 0 by default.
- R10: The completion pulse lasts one cycle. A request still held during that pulse cycle is not started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Data access request, held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 16 | Write data (bits 7:0 only for a byte write) |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read result, held until the next read finishes |
| ifq_pop | input | 1 | Remove the head instruction byte |
| ifq_valid | output | 1 | Queue holds at least one byte |
| ifq_byte | output | 8 | Head instruction byte |
| flush | input | 1 | Discard queue and restart prefetch |
| flush_addr | input | ADDR_W | New prefetch address used with flush |
| mem_addr | output | ADDR_W | External byte address |
| mem_dout | output | 8 | External write data |
| mem_din | input | 8 | External read data, sampled on the last clock of a read cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
A bad phase count or a wrong cycle-kind register shows within one bus cycle as a strobe that lasts other than 4 clocks, or as a completion pulse at the wrong latency. A stale or wrong fetch pointer appears at the very next pop as an unexpected head byte. This is most visible right after a flush, when the first delivered byte must come from the flush address. A mistake in word sequencing shows in the address and data order of the two write cycles, and in which byte lands in which half of the read result, no later than the completion pulse.

// File: rtl/bbu_pkg.sv
// Shared types for the byte-wide bus interface.
package bbu_pkg;

    // What the bus is doing in the current byte cycle.
    typedef enum logic [1:0] {
        KIND_IDLE  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_DATA  = 2'd2
    } xfer_kind_t;

endpackage

// File: rtl/bbu_phase_timer.sv
// Bus-cycle phase timer.
// Counts the clocks of one external byte cycle. A start pulse at an edge begins
// a new cycle at phase 0. The last flag is high during the final clock.
// Assumes start is raised only while idle or in the last phase.
module bbu_phase_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int PH_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC - 1);

    logic [PH_W-1:0] phase_q;
    logic            busy_q;

    // Advance the phase, restart on start, fall idle after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
        end else if (busy_q && phase_q == PH_LAST) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
        end else if (busy_q) begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (phase_q == PH_LAST);

endmodule

// File: rtl/bbu_fetch_queue.sv
// Instruction byte queue.
// A circular buffer of DEPTH bytes. Push, pop and flush all act at one edge.
// Flush wins over both. A pop on an empty queue is ignored. The space flag
// reports whether the count after this edge leaves a free slot. The sequencer
// uses it to decide whether a new fetch may start.
// Assumes the producer never pushes into a full queue.
module bbu_fetch_queue #(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [7:0]                   push_byte,
    input  logic                         pop,
    input  logic                         flush,
    output logic                         valid,
    output logic [7:0]                   head,
    output logic                         space,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [7:0]       slot_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q, rd_ptr_inc, wr_ptr_inc;
    logic [CNT_W-1:0] count_q, count_nxt;
    logic             do_push, do_pop;

    // Qualify the push and pop requests against flush and empty.
    always_comb begin
        do_push   = push && !flush;
        do_pop    = pop && !flush && (count_q != '0);
        count_nxt = flush ? '0 :
                    count_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    // Pointer wrap: a power-of-two depth wraps naturally, otherwise compare.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
            assign rd_ptr_inc = rd_ptr_q + PTR_W'(1);
            assign wr_ptr_inc = wr_ptr_q + PTR_W'(1);
        end else begin : g_wrap_cmp
            assign rd_ptr_inc = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
            assign wr_ptr_inc = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
        end
    endgenerate

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_inc;
            if (do_pop)  rd_ptr_q <= rd_ptr_inc;
            count_q <= count_nxt;
        end
    end

    // Byte storage, written at the tail.
    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_ptr_q] <= push_byte;
    end

    assign valid = (count_q != '0);
    assign head  = slot_q[rd_ptr_q];
    assign space = (count_nxt < CNT_FULL);
    assign count = count_q;

endmodule

// File: rtl/bbu_bus_sequencer.sv
// Bus-cycle sequencer and arbiter.
// At every cycle boundary it picks the next byte cycle. The high half of a word
// in progress comes first, then a pending data request, then a prefetch when
// the queue has room. It drives the registered external bus. It captures read
// data on the last clock, splits words into two byte cycles, and tracks the
// prefetch pointer and the discard flag for a flushed fetch.
// Assumes req_valid is held until req_done and the request fields are stable.
module bbu_bus_sequencer
    import bbu_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_FETCH = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_done,
    output logic [15:0]       req_rdata,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              q_space,
    output logic              q_push,
    output logic [7:0]        q_push_byte,
    output logic              t_start,
    input  logic              t_busy,
    input  logic              t_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dout,
    input  logic [7:0]        mem_din,
    output logic              mem_rd,
    output logic              mem_wr
);
    xfer_kind_t        kind_q;
    logic              hi_q, word_q, write_q, done_q, discard_q;
    logic [ADDR_W-1:0] daddr_q, fetch_ptr_q;
    logic [7:0]        wdata_hi_q;
    logic [15:0]       rdata_q;
    logic [ADDR_W-1:0] mem_addr_q;
    logic [7:0]        mem_dout_q;
    logic              mem_rd_q, mem_wr_q;

    logic              at_end, boundary, fetch_end, data_end, data_final;
    logic              start_hi, take_data, take_fetch;
    logic [ADDR_W-1:0] fetch_addr;

    // Arbitration at the cycle boundary: word high half, then data, then fetch.
    always_comb begin
        at_end     = t_busy && t_last;
        boundary   = !t_busy || t_last;
        fetch_end  = at_end && (kind_q == KIND_FETCH);
        data_end   = at_end && (kind_q == KIND_DATA);
        data_final = data_end && (!word_q || hi_q);
        start_hi   = data_end && word_q && !hi_q;
        take_data  = boundary && !start_hi && !data_final && req_valid && !done_q;
        take_fetch = boundary && !start_hi && !take_data && q_space;
        fetch_addr = flush ? flush_addr : fetch_ptr_q;
    end

    // Bus cycle launch, external strobes and data-access bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= KIND_IDLE;
            hi_q       <= 1'b0;
            word_q     <= 1'b0;
            write_q    <= 1'b0;
            daddr_q    <= '0;
            wdata_hi_q <= '0;
            mem_addr_q <= '0;
            mem_dout_q <= '0;
            mem_rd_q   <= 1'b0;
            mem_wr_q   <= 1'b0;
        end else if (start_hi) begin
            kind_q     <= KIND_DATA;
            hi_q       <= 1'b1;
            mem_addr_q <= daddr_q + ADDR_W'(1);
            mem_dout_q <= wdata_hi_q;
            mem_rd_q   <= !write_q;
            mem_wr_q   <= write_q;
        end else if (take_data) begin
            kind_q     <= KIND_DATA;
            hi_q       <= 1'b0;
            word_q     <= req_word;
            write_q    <= req_write;
            daddr_q    <= req_addr;
            wdata_hi_q <= req_wdata[15:8];
            mem_addr_q <= req_addr;
            mem_dout_q <= req_wdata[7:0];
            mem_rd_q   <= !req_write;
            mem_wr_q   <= req_write;
        end else if (take_fetch) begin
            kind_q     <= KIND_FETCH;
            hi_q       <= 1'b0;
            mem_addr_q <= fetch_addr;
            mem_dout_q <= '0;
            mem_rd_q   <= 1'b1;
            mem_wr_q   <= 1'b0;
        end else if (at_end) begin
            kind_q     <= KIND_IDLE;
            mem_rd_q   <= 1'b0;
            mem_wr_q   <= 1'b0;
        end
    end

    // Read capture on the last clock of a data read, and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= data_final;
            if (data_end && !write_q) begin
                if (hi_q) rdata_q[15:8] <= mem_din;
                else      rdata_q       <= {8'h00, mem_din};
            end
        end
    end

    // Prefetch pointer and the discard mark for a fetch overtaken by a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_ptr_q <= RESET_FETCH;
            discard_q   <= 1'b0;
        end else begin
            if (take_fetch)  fetch_ptr_q <= fetch_addr + ADDR_W'(1);
            else if (flush)  fetch_ptr_q <= flush_addr;
            if (take_fetch)
                discard_q <= 1'b0;
            else if (flush && t_busy && !t_last && kind_q == KIND_FETCH)
                discard_q <= 1'b1;
        end
    end

    assign q_push      = fetch_end && !discard_q && !flush;
    assign q_push_byte = mem_din;
    assign t_start     = start_hi || take_data || take_fetch;
    assign req_done    = done_q;
    assign req_rdata   = rdata_q;
    assign mem_addr    = mem_addr_q;
    assign mem_dout    = mem_dout_q;
    assign mem_rd      = mem_rd_q;
    assign mem_wr      = mem_wr_q;

endmodule

// File: rtl/byte_bus_unit.sv
// Byte-wide bus interface with instruction prefetch (top level).
// Joins the phase timer, the sequencer and the instruction queue. One external
// byte cycle lasts CYC clocks. Word accesses are split into two byte cycles.
// Prefetch fills a DEPTH-byte queue whenever the bus is otherwise free.
// Assumes a memory that answers a read within the cycle, with no wait states.
module byte_bus_unit #(
    parameter int                ADDR_W      = 16,
    parameter int                DEPTH       = 4,
    parameter int                CYC         = 4,
    parameter logic [ADDR_W-1:0] RESET_FETCH = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_done,
    output logic [15:0]       req_rdata,
    input  logic              ifq_pop,
    output logic              ifq_valid,
    output logic [7:0]        ifq_byte,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dout,
    input  logic [7:0]        mem_din,
    output logic              mem_rd,
    output logic              mem_wr
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             t_start, t_busy, t_last;
    logic             q_push, q_space;
    logic [7:0]       q_push_byte;
    logic [CNT_W-1:0] q_count;

    // Clock-count of the active byte cycle.
    bbu_phase_timer #(.CYC(CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .busy  (t_busy),
        .last  (t_last)
    );

    // Arbitration, word splitting and external bus drive.
    bbu_bus_sequencer #(.ADDR_W(ADDR_W), .RESET_FETCH(RESET_FETCH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_word    (req_word),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_done    (req_done),
        .req_rdata   (req_rdata),
        .flush       (flush),
        .flush_addr  (flush_addr),
        .q_space     (q_space),
        .q_push      (q_push),
        .q_push_byte (q_push_byte),
        .t_start     (t_start),
        .t_busy      (t_busy),
        .t_last      (t_last),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_din     (mem_din),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr)
    );

    // Instruction byte queue.
    bbu_fetch_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_byte (q_push_byte),
        .pop       (ifq_pop),
        .flush     (flush),
        .valid     (ifq_valid),
        .head      (ifq_byte),
        .space     (q_space),
        .count     (q_count)
    );

endmodule

// File: rtl/bbu_checker.sv
// Protocol checker for byte_bus_unit, attached by bind.
// Observes the external bus, the completion pulse, the queue flags and the
// queue occupancy. It tracks how long each strobe run lasts.
module bbu_checker #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int CYC    = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mem_rd,
    input logic                       mem_wr,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [7:0]                 mem_dout,
    input logic                       req_done,
    input logic                       ifq_valid,
    input logic                       flush,
    input logic [$clog2(DEPTH+1)-1:0] q_count
);
    logic              prev_rd, prev_wr;
    logic [ADDR_W-1:0] prev_addr;
    logic [7:0]        run_q;
    logic              strobe, same_cycle, run_ended;

    // Classify the sampled clock as a continuation of the previous strobe run.
    always_comb begin
        strobe     = mem_rd || mem_wr;
        same_cycle = strobe && (prev_rd || prev_wr) && (mem_addr == prev_addr)
                     && (mem_rd == prev_rd);
        run_ended  = (run_q != 8'd0) && !same_cycle;
    end

    // Remember the previous bus state and the length of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd   <= 1'b0;
            prev_wr   <= 1'b0;
            prev_addr <= '0;
            run_q     <= 8'd0;
        end else begin
            prev_rd   <= mem_rd;
            prev_wr   <= mem_wr;
            prev_addr <= mem_addr;
            run_q     <= !strobe ? 8'd0 : (same_cycle ? run_q + 8'd1 : 8'd1);
        end
    end

    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_cycle_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_ended |-> (run_q == 8'(CYC)));

    assert_run_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 8'(CYC));

    assert_wdata_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr) && mem_addr == $past(mem_addr)) |-> $stable(mem_dout));

    assert_done_after_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(mem_rd || mem_wr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ifq_valid);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!mem_rd && !mem_wr && !ifq_valid && !req_done));

endmodule

bind byte_bus_unit bbu_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CYC(CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .req_done  (req_done),
    .ifq_valid (ifq_valid),
    .flush     (flush),
    .q_count   (q_count)
);

// File: tb/byte_bus_unit_tb.sv
// Directed bench for byte_bus_unit: one task per scenario, each checks itself.
module byte_bus_unit_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_done;
    logic [15:0]   req_rdata;
    logic          ifq_pop = 1'b0;
    logic          ifq_valid;
    logic [7:0]    ifq_byte;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dout;
    logic [7:0]    mem_din;
    logic          mem_rd, mem_wr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    byte_bus_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata),
        .ifq_pop(ifq_pop), .ifq_valid(ifq_valid), .ifq_byte(ifq_byte),
        .flush(flush), .flush_addr(flush_addr),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    function automatic logic [7:0] init_b(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // Memory model: 256 bytes, filled during reset, written on the write strobe.
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_b(i);
        end else if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_dout;
        end
    end
    assign mem_din = mem_rd ? mem[mem_addr[7:0]] : 8'h00;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    // Issue one data access and log its strobe cycles until completion.
    task automatic access(input bit wr, input bit wd, input logic [15:0] a,
                          input logic [15:0] wdat, input bit hold,
                          output logic [15:0] rdat, output int lat, output int nstb,
                          output logic [15:0] a_first, output logic [15:0] a_last,
                          output logic [7:0] d_first, output logic [7:0] d_last);
        lat = 0; nstb = 0; a_first = '0; a_last = '0; d_first = '0; d_last = '0;
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat;
        while (lat < 40) begin
            @(posedge clk); @(negedge clk);
            lat++;
            if (wr ? mem_wr : mem_rd) begin
                nstb++;
                if (nstb == 1) begin a_first = mem_addr; d_first = mem_dout; end
                a_last = mem_addr; d_last = mem_dout;
            end
            if (req_done) break;
        end
        rdat = req_rdata;
        if (hold) begin
            @(posedge clk); @(negedge clk);
            if (wr ? mem_wr : mem_rd) nstb++;
        end
        req_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [7:0] e, input string rq);
        int w = 0;
        while (!ifq_valid && w < 100) begin @(posedge clk); @(negedge clk); w++; end
        chk(ifq_valid && ifq_byte == e, rq, "queue head byte", ifq_byte, e);
        ifq_pop = 1'b1;
        @(posedge clk); @(negedge clk);
        ifq_pop = 1'b0;
    endtask

    task automatic do_flush(input logic [AW-1:0] a);
        flush = 1'b1; flush_addr = a;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        chk(!ifq_valid, "R8", "queue empty after flush", ifq_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycles(5);
        chk(!mem_rd && !mem_wr, "R9", "strobes low in reset", {mem_rd, mem_wr}, 0);
        chk(!ifq_valid, "R9", "valid low in reset", ifq_valid, 0);
        chk(!req_done, "R9", "done low in reset", req_done, 0);
        rst_n = 1'b1;
        cycles(1);
        chk(mem_rd && mem_addr == 16'h0000, "R9", "first fetch from reset address",
            mem_addr, 0);
    endtask

    task automatic t_fill_and_pop();
        cycles(40);
        chk(!mem_rd && !mem_wr, "R5", "bus idle with full queue", mem_rd, 0);
        chk(ifq_valid, "R6", "valid with bytes queued", ifq_valid, 1);
        for (int i = 0; i < 4; i++) pop_expect(init_b(i), "R5");
    endtask

    task automatic t_flush_inflight();
        do_flush(16'h0040);
        ifq_pop = 1'b1;
        cycles(2);
        ifq_pop = 1'b0;
        chk(!ifq_valid, "R6", "pop on empty leaves queue empty", ifq_valid, 0);
        for (int i = 0; i < 4; i++) pop_expect(init_b(16'h40 + i), "R8");
    endtask

    task automatic t_byte_read();
        logic [15:0] rd, af, al; logic [7:0] df, dl; int lat, n;
        cycles(40);
        access(1'b0, 1'b0, 16'h0090, 16'h0, 1'b0, rd, lat, n, af, al, df, dl);
        chk(lat == 5, "R2", "byte read latency", lat, 5);
        chk(rd == {8'h00, init_b(16'h90)}, "R2", "byte read data", rd, {8'h00, init_b(16'h90)});
        chk(n == 4, "R1", "read strobe clocks", n, 4);
        chk(af == 16'h0090 && al == 16'h0090, "R1", "address held", al, 16'h0090);
    endtask

    task automatic t_word_read();
        logic [15:0] rd, af, al, ex; logic [7:0] df, dl; int lat, n;
        cycles(40);
        ex = {init_b(16'h93), init_b(16'h92)};
        access(1'b0, 1'b1, 16'h0092, 16'h0, 1'b0, rd, lat, n, af, al, df, dl);
        chk(lat == 9, "R3", "word read latency", lat, 9);
        chk(n == 8, "R3", "two byte cycles", n, 8);
        chk(af == 16'h0092 && al == 16'h0093, "R3", "low then high address", al, 16'h0093);
        chk(rd == ex, "R3", "word assembled", rd, ex);
    endtask

    task automatic t_word_write();
        logic [15:0] rd, af, al; logic [7:0] df, dl; int lat, n;
        cycles(40);
        access(1'b1, 1'b1, 16'h00A0, 16'hBEEF, 1'b0, rd, lat, n, af, al, df, dl);
        chk(lat == 9, "R4", "word write latency", lat, 9);
        chk(n == 8, "R4", "write strobe clocks", n, 8);
        chk(df == 8'hEF && dl == 8'hBE, "R4", "low byte then high byte", {df, dl}, 16'hEFBE);
        chk(af == 16'h00A0 && al == 16'h00A1, "R4", "write addresses", al, 16'h00A1);
        access(1'b0, 1'b1, 16'h00A0, 16'h0, 1'b0, rd, lat, n, af, al, df, dl);
        chk(rd == 16'hBEEF, "R4", "word read back", rd, 16'hBEEF);
    endtask

    task automatic t_done_hold();
        logic [15:0] rd, af, al; logic [7:0] df, dl; int lat, n, extra;
        cycles(40);
        access(1'b1, 1'b0, 16'h00B0, 16'h775C, 1'b1, rd, lat, n, af, al, df, dl);
        chk(n == 4, "R10", "held request not restarted", n, 4);
        extra = 0;
        for (int i = 0; i < 8; i++) begin
            cycles(1);
            if (mem_wr || req_done) extra++;
        end
        chk(extra == 0, "R10", "no second write or pulse", extra, 0);
        access(1'b0, 1'b0, 16'h00B1, 16'h0, 1'b0, rd, lat, n, af, al, df, dl);
        chk(rd == {8'h00, init_b(16'hB1)}, "R1", "byte write leaves neighbour",
            rd, {8'h00, init_b(16'hB1)});
        access(1'b0, 1'b0, 16'h00B0, 16'h0, 1'b0, rd, lat, n, af, al, df, dl);
        chk(rd == 16'h005C, "R2", "byte write read back", rd, 16'h005C);
    endtask

    task automatic t_arbitration();
        logic [15:0] rd, af, al; logic [7:0] df, dl; int lat, n;
        do_flush(16'h0060);
        cycles(1);
        access(1'b0, 1'b0, 16'h0094, 16'h0, 1'b0, rd, lat, n, af, al, df, dl);
        chk(lat >= 5 && lat <= 8, "R7", "data wins next boundary", lat, 8);
        chk(rd == {8'h00, init_b(16'h94)}, "R7", "read during prefetch", rd,
            {8'h00, init_b(16'h94)});
        for (int i = 0; i < 4; i++) pop_expect(init_b(16'h60 + i), "R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_and_pop();
        t_flush_inflight();
        t_byte_read();
        t_word_read();
        t_word_write();
        t_done_hold();
        t_arbitration();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule